// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Clear Unit

This unit gathers the twelve event sources of an I2C controller into one status word and drives a single interrupt line from it. Pulsed events are held in sticky bits until software clears them. Software clears them by reading clear addresses, not by writing. It can clear everything at once, clear one source, or clear the transfer-abort state together with the captured abort reasons.

Two of the status bits are not stored. They are live comparisons of the FIFO fill levels against two programmable thresholds. The receive-full bit is set while the RX level is above its threshold, so a threshold of N-1 fires at N entries. The transmit-empty bit is set while the TX level is at or below its threshold.

An abort-source register collects the reason bits given with every abort event. A nonzero value marks a failed transfer.

Top module: `i2c_irq_unit`

## Requirements
- R1: Status bit positions are: 0 RX underflow, 1 RX overflow, 2 RX full, 3 TX overflow, 4 TX empty, 5 read request, 6 TX abort, 7 RX done, 8 activity, 9 stop seen, 10 start seen, 11 general call. A one-cycle pulse on `evt_i[k]` sets sticky bit k for every k except 2 and 4. That bit is visible at address 0 (raw status) in the next cycle. Pulses on `evt_i[2]` and `evt_i[4]` have no effect.
- R2: Address 1 is a read/write mask with the same bit layout. `irq_o` is high exactly when some raw status bit and its mask bit are both set. Address 2 reads raw status AND mask.
- R3: A read of address 5 returns the raw status and clears every sticky bit, including TX abort. It does not clear the abort-source register.
- R4: A read of address 8+k returns raw bit k in data bit 0. It clears only sticky bit k (k other than 2, 4 and 6). Such a read has no effect on the live bits 2 and 4.
- R5: Each TX abort pulse ORs `abort_src_i` into the abort-source register, which is read at address 7. A read of address 6 returns that register and clears both it and status bit 6.
- R6: Address 3 holds the RX threshold (reset 0). Status bit 2 equals `rx_level_i > threshold`, independent of any clear read.
- R7: Address 4 holds the TX threshold (reset 0). Status bit 4 equals `tx_level_i <= threshold`, independent of any clear read.
- R8: If a clear read and a new event for the same bit occur in the same cycle, the bit stays set.
- R9: After reset the mask, sticky bits, abort source and thresholds are zero, and `irq_o` depends only on the live bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 12 | Event pulses, one per status bit |
| abort_src_i | input | 16 | Abort reasons, valid with `evt_i[6]` |
| tx_level_i | input | 5 | TX FIFO fill level |
| rx_level_i | input | 5 | RX FIFO fill level |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data (combinational, zero when not reading) |
| irq_o | output | 1 | Interrupt line |

## Verification
The hardest case to reach from the ports is a clear read and a fresh event for the same bit arriving in the same clock. The bench drives this with a combined task that asserts the read strobe on a clear address and the event pulse in one cycle. It then reads raw status to confirm the bit survived. The bench also moves the FIFO levels across each threshold, one step either side of the boundary, and issues clear reads while a live bit is high.

// File: rtl/i2c_irq_unit.sv
module i2c_irq_unit #(
  parameter int LVL_W      = 5,
  parameter int ABRT_W     = 16,
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 5,
  parameter int RX_THR_RST = 0,
  parameter int TX_THR_RST = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       evt_i,
  input  logic [ABRT_W-1:0] abort_src_i,
  input  logic [LVL_W-1:0]  tx_level_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int NSRC = 12;
  localparam logic [NSRC-1:0] LIVE   = 12'h014;
  localparam logic [NSRC-1:0] STICKY = ~LIVE;
  localparam int ABT_BIT = 6;
  localparam logic [ADDR_W-1:0] A_RAW    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_RXTHR  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_TXTHR  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CLRALL = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_CLRABT = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_ABTSRC = ADDR_W'(7);
  localparam int CLR_BASE = 8;

  logic [NSRC-1:0]   sticky_q, mask_q, clr, raw;
  logic [LVL_W-1:0]  rxthr_q, txthr_q;
  logic [ABRT_W-1:0] abt_q;

  wire rx_full    = rx_level_i > rxthr_q;
  wire tx_empty   = tx_level_i <= txthr_q;
  wire clr_all_rd = rd_en_i && addr_i == A_CLRALL;
  wire clr_abt_rd = rd_en_i && addr_i == A_CLRABT;
  wire unused_ok  = ^wdata_i;

  assign raw   = (sticky_q & STICKY) | {7'b0, tx_empty, 1'b0, rx_full, 2'b0};
  assign irq_o = |(raw & mask_q);

  always_comb begin
    clr = {NSRC{clr_all_rd}};
    clr[ABT_BIT] = clr[ABT_BIT] | clr_abt_rd;
    for (int i = 0; i < NSRC; i++)
      if (rd_en_i && i != ABT_BIT && addr_i == ADDR_W'(CLR_BASE + i))
        clr[i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
      abt_q    <= '0;
    end else begin
      sticky_q <= ((sticky_q & ~clr) | evt_i) & STICKY;
      if (evt_i[ABT_BIT])
        abt_q <= (clr_abt_rd ? '0 : abt_q) | abort_src_i;
      else if (clr_abt_rd)
        abt_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      rxthr_q <= LVL_W'(RX_THR_RST);
      txthr_q <= LVL_W'(TX_THR_RST);
    end else if (wr_en_i) begin
      case (addr_i)
        A_MASK:  mask_q  <= wdata_i[NSRC-1:0];
        A_RXTHR: rxthr_q <= wdata_i[LVL_W-1:0];
        A_TXTHR: txthr_q <= wdata_i[LVL_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr_i)
        A_RAW, A_CLRALL: rdata_o = DATA_W'(raw);
        A_MASK:          rdata_o = DATA_W'(mask_q);
        A_PEND:          rdata_o = DATA_W'(raw & mask_q);
        A_RXTHR:         rdata_o = DATA_W'(rxthr_q);
        A_TXTHR:         rdata_o = DATA_W'(txthr_q);
        A_ABTSRC, A_CLRABT: rdata_o = DATA_W'(abt_q);
        default:
          for (int i = 0; i < NSRC; i++)
            if (addr_i == ADDR_W'(CLR_BASE + i)) rdata_o = DATA_W'(raw[i]);
      endcase
    end
  end

  // R1 R8
  evt_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & STICKY) != '0) |=> ((raw & $past(evt_i & STICKY)) == $past(evt_i & STICKY)));

  // R1
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en_i && (evt_i & STICKY) == '0) |=> ((raw & STICKY) == $past(raw & STICKY)));

  // R2
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

  // R3
  clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all_rd && (evt_i & STICKY) == '0) |=> ((raw & STICKY) == '0));

  // R5
  abt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_abt_rd && !evt_i[ABT_BIT]) |=> (abt_q == '0 && !raw[ABT_BIT]));
endmodule

// File: tb/i2c_irq_unit_test.sv
module i2c_irq_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLRB = 8;

  logic        clk = 0, rst_n = 0;
  logic [11:0] evt = '0;
  logic [15:0] asrc = '0, wdata = '0;
  logic [4:0]  txl = '0, rxl = '0, addr = '0;
  logic        rd_en = 0, wr_en = 0;
  logic [15:0] rdata;
  logic        irq;

  int nvec = 0, nbad = 0;
  int exp_q[$];
  string tag_q[$];

  i2c_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .abort_src_i(asrc),
    .tx_level_i(txl), .rx_level_i(rxl), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (rd_en && exp_q.size() > 0) begin
      int e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      nvec++;
      if (rdata !== 16'(e)) begin
        nbad++;
        $display("FAIL %s addr=%0d got=%h exp=%h", t, addr, rdata, 16'(e));
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    rd_en = 0; wr_en = 0; evt = '0; asrc = '0;
  endtask

  task automatic rd(input int a, input int e, input string t);
    step();
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1; addr = 5'(a);
  endtask

  task automatic rd_evt(input int a, input logic [11:0] ev, input int e, input string t);
    step();
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1; addr = 5'(a); evt = ev;
  endtask

  task automatic wr(input int a, input int d);
    step();
    wr_en = 1; addr = 5'(a); wdata = 16'(d);
  endtask

  task automatic pulse(input logic [11:0] ev, input logic [15:0] s);
    step();
    evt = ev; asrc = s;
  endtask

  task automatic set_lvl(input int t, input int r);
    step();
    txl = 5'(t); rxl = 5'(r);
  endtask

  task automatic chk_irq(input logic e, input string t);
    step();
    @(negedge clk);
    nvec++;
    if (irq !== e) begin
      nbad++;
      $display("FAIL %s irq got=%b exp=%b", t, irq, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R9 reset state: TX level 0 <= threshold 0 makes bit 4 live
    rd(0, 'h010, "R9"); rd(1, 0, "R9"); rd(7, 0, "R9");
    rd(3, 0, "R9"); rd(4, 0, "R9"); chk_irq(0, "R9");
    set_lvl(5, 0); rd(0, 0, "R7");
    // R1 sticky events; live bits ignore pulses
    pulse('h201, 0); rd(0, 'h201, "R1");
    pulse('h014, 0); rd(0, 'h201, "R1");
    // R2 mask
    wr(1, 'h200); chk_irq(1, "R2"); rd(2, 'h200, "R2");
    // R4 per-source clear
    rd(CLRB + 9, 1, "R4"); rd(0, 'h001, "R4"); chk_irq(0, "R2");
    // R3 combined clear
    pulse('h880, 0); rd(0, 'h881, "R1");
    rd(5, 'h881, "R3"); rd(0, 0, "R3");
    // R8 clear and event together
    pulse('h001, 0); rd_evt(CLRB, 'h001, 1, "R8"); rd(0, 'h001, "R8");
    rd_evt(5, 'h400, 'h001, "R8"); rd(0, 'h400, "R8");
    rd(5, 'h400, "R3"); rd(0, 0, "R3");
    // R5 abort source accumulation and clear
    pulse('h040, 16'h0011); pulse('h040, 16'h0100);
    rd(7, 'h0111, "R5"); rd(0, 'h040, "R5");
    rd(5, 'h040, "R3"); rd(0, 0, "R3"); rd(7, 'h0111, "R5");
    rd(6, 'h0111, "R5"); rd(7, 0, "R5");
    pulse('h040, 16'h8000); rd(6, 'h8000, "R5"); rd(0, 0, "R5");
    // R6 RX threshold
    wr(3, 3); rd(3, 3, "R6");
    set_lvl(5, 3); rd(0, 0, "R6");
    set_lvl(5, 4); rd(0, 'h004, "R6");
    rd(5, 'h004, "R6"); rd(0, 'h004, "R6");
    wr(1, 'h004); chk_irq(1, "R2");
    set_lvl(5, 2); chk_irq(0, "R6");
    // R7 TX threshold
    wr(4, 4); rd(0, 0, "R7");
    set_lvl(4, 2); rd(0, 'h010, "R7");
    rd(CLRB + 4, 1, "R4"); rd(0, 'h010, "R4");
    set_lvl(3, 0); rd(0, 'h010, "R7");
    set_lvl(5, 0); rd(0, 0, "R7");
    step(); step();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule